// File: doc/BRIEF.md
# Guest Priority Shadow Trap Monitor

This block holds a guest's virtualized task-priority byte and decides when a change to it must hand control back to the hypervisor. The guest can write the priority in three ways: a 4-bit control-register write, a byte store into the virtual interrupt-controller page at the priority offset, and a write to a numbered system register whose index selects the priority register. Each way has its own enable bits. An accepted write updates the shadow byte and issues a write of that byte to the backing page. The block then compares the priority class (the upper nibble) against a 4-bit threshold and, if the class is lower, emits a one-cycle exit request.

The hypervisor programs the page base, which must sit on a 4 KiB boundary while shadowing is on, and the threshold word, of which only the low nibble matters. The backing memory and the rest of the interrupt-controller model are outside this block.

Top module: `prio_shadow_monitor`

## Requirements
- R1: After reset, `shadow_byte` is 00h, and `page_wr_en`, `exit_pulse` and `cfg_err` are 0.
- R2: With `cfg_shadow_en`=1, a `cr_wr_vld` strobe with value v makes `shadow_byte` equal {v, 4'b0000} and `page_wr_en`=1 with `page_wr_data` equal to that byte, both in the cycle after the strobe.
- R3: A `mem_wr_vld` strobe updates the shadow with `mem_wr_data` only when `mem_wr_off`=080h and both `cfg_shadow_en` and `cfg_mmio_virt_en` are 1; any other offset or a clear enable leaves shadow and page write unchanged.
- R4: An `idx_wr_vld` strobe updates the shadow with `idx_wr_data` only when `idx_wr_idx`=808h and both `cfg_shadow_en` and `cfg_idx_virt_en` are 1; otherwise it is ignored.
- R5: With `cfg_shadow_en`=0, all three paths are ignored and `exit_pulse` stays 0.
- R6: When several paths strobe in the same cycle and are eligible, the control-register path wins, then the memory path, then the index path; the losers have no effect.
- R7: After an accepted write, `exit_pulse` is 1 for exactly one cycle, two cycles after the strobe (one cycle after the shadow changes), if and only if the new `shadow_byte[7:4]` is less than `cfg_threshold[3:0]`; bits 31:4 of the threshold have no effect.
- R8: `cfg_err` is 1, one cycle after the configuration, exactly when `cfg_shadow_en`=1 and `cfg_page_base[11:0]` is not zero.
- R9: `page_wr_addr` of an accepted write equals `cfg_page_base` with bits 11:0 replaced by 080h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shadow_en | input | 1 | Master enable for priority shadowing |
| cfg_mmio_virt_en | input | 1 | Enables the page-store path |
| cfg_idx_virt_en | input | 1 | Enables the indexed register write path |
| cfg_page_base | input | ADDR_W | Virtual interrupt-controller page base |
| cfg_threshold | input | THR_W | Threshold word, low nibble used |
| cr_wr_vld | input | 1 | Control-register write strobe |
| cr_wr_val | input | PRIO_W | Control-register priority value |
| mem_wr_vld | input | 1 | Page byte store strobe |
| mem_wr_off | input | OFF_W | Store offset within the page |
| mem_wr_data | input | 8 | Store byte |
| idx_wr_vld | input | 1 | Indexed register write strobe |
| idx_wr_idx | input | IDX_W | Register index |
| idx_wr_data | input | 8 | Register write byte |
| shadow_byte | output | 8 | Current shadow priority byte |
| page_wr_en | output | 1 | Page write enable |
| page_wr_addr | output | ADDR_W | Page write byte address |
| page_wr_data | output | 8 | Page write byte |
| exit_pulse | output | 1 | One-cycle exit request |
| cfg_err | output | 1 | Misaligned page base while enabled |

## Verification
A wrong shadow value shows on `shadow_byte` and `page_wr_data` one cycle after the strobe and, through the comparison, as a missing or extra `exit_pulse` one cycle later. A wrong gating or arbitration decision shows as a page write that should not happen, or a byte from the losing path, in that same first cycle. The bench sweeps every control value against every threshold nibble, every store byte, and all enable combinations, so a fault in the comparator or the gating shows within two cycles of the offending write.

// File: rtl/prio_shadow_pkg.sv
package prio_shadow_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CR   = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_IDX  = 2'd3
  } wr_src_e;
endpackage

// File: rtl/prio_path_arbiter.sv
module prio_path_arbiter
  import prio_shadow_pkg::*;
#(
  parameter int PRIO_W     = 4,
  parameter int OFF_W      = 12,
  parameter int IDX_W      = 32,
  parameter logic [OFF_W-1:0] PRIO_OFF = 12'h080,
  parameter logic [IDX_W-1:0] PRIO_IDX = 32'h0000_0808
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_shadow,
  input  logic              en_mmio,
  input  logic              en_idx,
  input  logic              cr_vld,
  input  logic [PRIO_W-1:0] cr_val,
  input  logic              mem_vld,
  input  logic [OFF_W-1:0]  mem_off,
  input  logic [7:0]        mem_data,
  input  logic              idx_vld,
  input  logic [IDX_W-1:0]  idx_num,
  input  logic [7:0]        idx_data,
  output wr_src_e           src,
  output logic              accept,
  output logic [7:0]        new_byte
);
  localparam int LOW_W = 8 - PRIO_W;

  logic cr_ok, mem_ok, idx_ok;

  always_comb begin
    cr_ok  = en_shadow && cr_vld;
    mem_ok = en_shadow && en_mmio && mem_vld && (mem_off == PRIO_OFF);
    idx_ok = en_shadow && en_idx && idx_vld && (idx_num == PRIO_IDX);
  end

  always_comb begin
    src      = SRC_NONE;
    new_byte = '0;
    if (cr_ok) begin
      src      = SRC_CR;
      new_byte = {cr_val, {LOW_W{1'b0}}};
    end else if (mem_ok) begin
      src      = SRC_MEM;
      new_byte = mem_data;
    end else if (idx_ok) begin
      src      = SRC_IDX;
      new_byte = idx_data;
    end
    accept = (src != SRC_NONE);
  end

  // R5
  no_accept_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_shadow |-> !accept);

  // R6
  cr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (en_shadow && cr_vld) |-> (src == SRC_CR));
endmodule

// File: rtl/prio_shadow_reg.sv
module prio_shadow_reg
  import prio_shadow_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12,
  parameter int PRIO_W = 4,
  parameter logic [OFF_W-1:0] PRIO_OFF = 12'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  wr_src_e           src,
  input  logic [7:0]        new_byte,
  input  logic [ADDR_W-1:0] page_base,
  output logic [7:0]        shadow_byte,
  output logic              page_wr_en,
  output logic [ADDR_W-1:0] page_wr_addr,
  output logic [7:0]        page_wr_data
);
  localparam int LOW_W = 8 - PRIO_W;

  logic last_from_cr;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_byte  <= '0;
      page_wr_en   <= 1'b0;
      page_wr_addr <= '0;
      page_wr_data <= '0;
      last_from_cr <= 1'b0;
    end else begin
      page_wr_en   <= accept;
      last_from_cr <= accept && (src == SRC_CR);
      if (accept) begin
        shadow_byte  <= new_byte;
        page_wr_data <= new_byte;
        page_wr_addr <= {page_base[ADDR_W-1:OFF_W], PRIO_OFF};
      end
    end
  end

  // R2
  cr_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
    last_from_cr |-> (shadow_byte[LOW_W-1:0] == '0));

  // R9
  page_addr_offset_chk: assert property (@(posedge clk) disable iff (rst)
    page_wr_en |-> (page_wr_addr[OFF_W-1:0] == PRIO_OFF));
endmodule

// File: rtl/prio_trap_gen.sv
module prio_trap_gen #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [PRIO_W-1:0] new_prio,
  input  logic [PRIO_W-1:0] thr,
  output logic              exit_pulse
);
  logic trap_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pend  <= 1'b0;
      exit_pulse <= 1'b0;
    end else begin
      trap_pend  <= accept && (new_prio < thr);
      exit_pulse <= trap_pend;
    end
  end
endmodule

// File: rtl/prio_shadow_monitor.sv
module prio_shadow_monitor
  import prio_shadow_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 32,
  parameter int THR_W  = 32,
  parameter int PRIO_W = 4,
  parameter logic [OFF_W-1:0] PRIO_OFF = 12'h080,
  parameter logic [IDX_W-1:0] PRIO_IDX = 32'h0000_0808
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_shadow_en,
  input  logic              cfg_mmio_virt_en,
  input  logic              cfg_idx_virt_en,
  input  logic [ADDR_W-1:0] cfg_page_base,
  input  logic [THR_W-1:0]  cfg_threshold,
  input  logic              cr_wr_vld,
  input  logic [PRIO_W-1:0] cr_wr_val,
  input  logic              mem_wr_vld,
  input  logic [OFF_W-1:0]  mem_wr_off,
  input  logic [7:0]        mem_wr_data,
  input  logic              idx_wr_vld,
  input  logic [IDX_W-1:0]  idx_wr_idx,
  input  logic [7:0]        idx_wr_data,
  output logic [7:0]        shadow_byte,
  output logic              page_wr_en,
  output logic [ADDR_W-1:0] page_wr_addr,
  output logic [7:0]        page_wr_data,
  output logic              exit_pulse,
  output logic              cfg_err
);
  localparam int PRIO_LSB = 8 - PRIO_W;

  wr_src_e           src;
  logic              accept;
  logic [7:0]        new_byte;
  logic [PRIO_W-1:0] thr_nib;

  assign thr_nib = cfg_threshold[PRIO_W-1:0];

  prio_path_arbiter #(
    .PRIO_W(PRIO_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PRIO_OFF(PRIO_OFF), .PRIO_IDX(PRIO_IDX)
  ) u_arb (
    .clk(clk), .rst(rst),
    .en_shadow(cfg_shadow_en), .en_mmio(cfg_mmio_virt_en), .en_idx(cfg_idx_virt_en),
    .cr_vld(cr_wr_vld), .cr_val(cr_wr_val),
    .mem_vld(mem_wr_vld), .mem_off(mem_wr_off), .mem_data(mem_wr_data),
    .idx_vld(idx_wr_vld), .idx_num(idx_wr_idx), .idx_data(idx_wr_data),
    .src(src), .accept(accept), .new_byte(new_byte)
  );

  prio_shadow_reg #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PRIO_W(PRIO_W), .PRIO_OFF(PRIO_OFF)
  ) u_reg (
    .clk(clk), .rst(rst), .accept(accept), .src(src), .new_byte(new_byte),
    .page_base(cfg_page_base), .shadow_byte(shadow_byte),
    .page_wr_en(page_wr_en), .page_wr_addr(page_wr_addr), .page_wr_data(page_wr_data)
  );

  prio_trap_gen #(.PRIO_W(PRIO_W)) u_trap (
    .clk(clk), .rst(rst), .accept(accept),
    .new_prio(new_byte[7:PRIO_LSB]), .thr(thr_nib), .exit_pulse(exit_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_shadow_en && (cfg_page_base[OFF_W-1:0] != '0);
  end

  // R7
  exit_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> ($past(page_wr_en) &&
                    ($past(shadow_byte[7:PRIO_LSB]) < $past(thr_nib, 2))));

  // R7
  exit_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    (page_wr_en && (shadow_byte[7:PRIO_LSB] < $past(thr_nib))) |=> exit_pulse);

  // R8
  cfg_err_off_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_shadow_en));
endmodule

// File: tb/tb_prio_shadow_monitor.sv
module tb_prio_shadow_monitor;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_shadow_en, cfg_mmio_virt_en, cfg_idx_virt_en;
  logic [63:0] cfg_page_base;
  logic [31:0] cfg_threshold;
  logic        cr_wr_vld;
  logic [3:0]  cr_wr_val;
  logic        mem_wr_vld;
  logic [11:0] mem_wr_off;
  logic [7:0]  mem_wr_data;
  logic        idx_wr_vld;
  logic [31:0] idx_wr_idx;
  logic [7:0]  idx_wr_data;
  logic [7:0]  shadow_byte;
  logic        page_wr_en;
  logic [63:0] page_wr_addr;
  logic [7:0]  page_wr_data;
  logic        exit_pulse;
  logic        cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model_shadow;

  always #5 clk = ~clk;

  prio_shadow_monitor dut (
    .clk(clk), .rst(rst),
    .cfg_shadow_en(cfg_shadow_en), .cfg_mmio_virt_en(cfg_mmio_virt_en),
    .cfg_idx_virt_en(cfg_idx_virt_en), .cfg_page_base(cfg_page_base),
    .cfg_threshold(cfg_threshold),
    .cr_wr_vld(cr_wr_vld), .cr_wr_val(cr_wr_val),
    .mem_wr_vld(mem_wr_vld), .mem_wr_off(mem_wr_off), .mem_wr_data(mem_wr_data),
    .idx_wr_vld(idx_wr_vld), .idx_wr_idx(idx_wr_idx), .idx_wr_data(idx_wr_data),
    .shadow_byte(shadow_byte), .page_wr_en(page_wr_en), .page_wr_addr(page_wr_addr),
    .page_wr_data(page_wr_data), .exit_pulse(exit_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One write cycle on any mix of paths, then checks of shadow, page write and exit.
  task automatic do_wr(input string req,
                       input logic cv, input logic [3:0] cd,
                       input logic mv, input logic [11:0] mo, input logic [7:0] md,
                       input logic iv, input logic [31:0] ii, input logic [7:0] id);
    logic acc;
    logic [7:0] nb;
    logic [3:0] thr;
    acc = 1'b0; nb = model_shadow;
    if (cfg_shadow_en) begin
      if (cv) begin acc = 1'b1; nb = {cd, 4'h0}; end
      else if (mv && cfg_mmio_virt_en && mo == 12'h080) begin acc = 1'b1; nb = md; end
      else if (iv && cfg_idx_virt_en && ii == 32'h808) begin acc = 1'b1; nb = id; end
    end
    thr = cfg_threshold[3:0];
    @(negedge clk);
    cr_wr_vld = cv; cr_wr_val = cd;
    mem_wr_vld = mv; mem_wr_off = mo; mem_wr_data = md;
    idx_wr_vld = iv; idx_wr_idx = ii; idx_wr_data = id;
    @(negedge clk);
    cr_wr_vld = 1'b0; mem_wr_vld = 1'b0; idx_wr_vld = 1'b0;
    model_shadow = nb;
    chk({req, " shadow"}, {56'd0, shadow_byte}, {56'd0, nb});
    chk({req, " wr_en"}, {63'd0, page_wr_en}, {63'd0, acc});
    if (acc) begin
      chk({req, " wr_data"}, {56'd0, page_wr_data}, {56'd0, nb});
      chk("R9 wr_addr", page_wr_addr, {cfg_page_base[63:12], 12'h080});
    end
    chk({req, " exit"}, {63'd0, exit_pulse}, 64'd0);
    @(negedge clk);
    chk({req, " R7 exit"}, {63'd0, exit_pulse}, {63'd0, acc && (nb[7:4] < thr)});
    @(negedge clk);
    chk("R7 exit width", {63'd0, exit_pulse}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_shadow_en = 1'b1; cfg_mmio_virt_en = 1'b1; cfg_idx_virt_en = 1'b1;
    cfg_page_base = 64'h0000_1234_5678_9000;
    cfg_threshold = 32'h0;
    cr_wr_vld = 0; cr_wr_val = 0; mem_wr_vld = 0; mem_wr_off = 0; mem_wr_data = 0;
    idx_wr_vld = 0; idx_wr_idx = 0; idx_wr_data = 0;
    model_shadow = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 shadow", {56'd0, shadow_byte}, 64'd0);
    chk("R1 wr_en", {63'd0, page_wr_en}, 64'd0);
    chk("R1 exit", {63'd0, exit_pulse}, 64'd0);
    chk("R1 cfg_err", {63'd0, cfg_err}, 64'd0);

    // R2 / R7: every control value against every threshold nibble, noisy upper bits
    for (int t = 0; t < 16; t++) begin
      cfg_threshold = 32'hDEAD_BEE0 | 32'(t);
      for (int v = 0; v < 16; v++)
        do_wr("R2", 1'b1, 4'(v), 1'b0, 12'h0, 8'h0, 1'b0, 32'h0, 8'h0);
    end

    // R3: every store byte at the priority offset
    cfg_threshold = 32'h0000_0009;
    for (int d = 0; d < 256; d++)
      do_wr("R3", 1'b0, 4'h0, 1'b1, 12'h080, 8'(d), 1'b0, 32'h0, 8'h0);
    do_wr("R3 offset", 1'b0, 4'h0, 1'b1, 12'h081, 8'h11, 1'b0, 32'h0, 8'h0);
    do_wr("R3 offset", 1'b0, 4'h0, 1'b1, 12'h000, 8'h22, 1'b0, 32'h0, 8'h0);

    // R4: every byte through the index path, and wrong indices
    for (int d = 0; d < 256; d++)
      do_wr("R4", 1'b0, 4'h0, 1'b0, 12'h0, 8'h0, 1'b1, 32'h808, 8'(d));
    do_wr("R4 index", 1'b0, 4'h0, 1'b0, 12'h0, 8'h0, 1'b1, 32'h809, 8'h33);
    do_wr("R4 index", 1'b0, 4'h0, 1'b0, 12'h0, 8'h0, 1'b1, 32'h1808, 8'h44);

    // R6: priority among simultaneous strobes
    do_wr("R6 all", 1'b1, 4'h7, 1'b1, 12'h080, 8'h55, 1'b1, 32'h808, 8'h66);
    do_wr("R6 mem>idx", 1'b0, 4'h0, 1'b1, 12'h080, 8'h12, 1'b1, 32'h808, 8'h99);
    do_wr("R6 bad mem", 1'b0, 4'h0, 1'b1, 12'h084, 8'h12, 1'b1, 32'h808, 8'hA5);

    // R3/R4/R6: sub-enable combinations with all paths strobing
    for (int m = 0; m < 4; m++) begin
      cfg_mmio_virt_en = m[0]; cfg_idx_virt_en = m[1];
      do_wr("R3 R4 gate", 1'b0, 4'h0, 1'b1, 12'h080, 8'h21 + 8'(m),
            1'b1, 32'h808, 8'hC3 + 8'(m));
    end
    cfg_mmio_virt_en = 1'b1; cfg_idx_virt_en = 1'b1;

    // R5: master enable clear, low threshold condition would otherwise trap
    cfg_shadow_en = 1'b0; cfg_threshold = 32'hF;
    do_wr("R5 cr", 1'b1, 4'h1, 1'b0, 12'h0, 8'h0, 1'b0, 32'h0, 8'h0);
    do_wr("R5 mem", 1'b0, 4'h0, 1'b1, 12'h080, 8'h10, 1'b0, 32'h0, 8'h0);
    do_wr("R5 idx", 1'b0, 4'h0, 1'b0, 12'h0, 8'h0, 1'b1, 32'h808, 8'h10);
    do_wr("R5 all", 1'b1, 4'h0, 1'b1, 12'h080, 8'h00, 1'b1, 32'h808, 8'h00);

    // R8: alignment error flag over enable and base low bits
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 4; b++) begin
        cfg_shadow_en = e[0];
        cfg_page_base = 64'hABCD_0000_0000_0000 | (b == 0 ? 64'h0 :
                        b == 1 ? 64'h1 : b == 2 ? 64'h800 : 64'h1000);
        @(negedge clk);
        @(negedge clk);
        chk("R8 cfg_err", {63'd0, cfg_err},
            {63'd0, (e == 1) && (cfg_page_base[11:0] != 12'h0)});
      end
    end

    // R9: aligned-away address bits with a misaligned base
    cfg_shadow_en = 1'b1; cfg_page_base = 64'h0000_7777_0000_3FFF;
    do_wr("R9", 1'b1, 4'hA, 1'b0, 12'h0, 8'h0, 1'b0, 32'h0, 8'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule